// File: doc/BRIEF.md
# Continuous Multi-Channel Scan Sequencer

This block drives an A/D converter around a set of enabled analog inputs and never stops on its own. An 8-bit enable mask picks the inputs, one bit for each input. A start bit held inside the block begins the scan. The sequencer selects the lowest enabled input, raises a one-cycle sample strobe and waits for the converter to return a done pulse with a 12-bit result. It stores that result in the data register of the selected input and sets the input's valid flag. It then moves to the next enabled input above the current one. After the highest enabled input it returns to the lowest one.

Software ends the scan by writing zero to the start bit. The conversion that is already under way still completes and its result is stored. After that the sequencer goes idle and issues no more strobes. A read port returns any input's data register and valid flag, and a read clears that flag. If the scan is started while the mask has no bit set, the start bit drops again at once and no sample is taken.

Top module: `adc_scan_sequencer`

## Requirements
- R1: After reset the start bit, the sample strobe and every valid flag read 0.
- R2: When the start bit is set and the mask is non-zero, the first sample strobe selects the lowest-numbered enabled input.
- R3: Each later strobe selects the lowest enabled input numbered above the previous one. Inputs whose mask bit is 0 are never selected.
- R4: After the highest enabled input the next strobe selects the lowest enabled input, and the scan goes on for as long as the start bit stays 1.
- R5: The sample strobe is high for exactly one clock cycle for each conversion. Channel select holds the input being converted until the done pulse arrives.
- R6: On a done pulse the 12-bit result is written into the data register of the selected input, and that input's valid flag (bit n of the flag vector, n being the input number) becomes 1.
- R7: Reading an input returns its data and its valid flag in the same cycle. A read pulse clears the flag on the next clock edge. If a done pulse for the same input arrives in the same cycle, the write wins.
- R8: When the start bit is written to 0 during a conversion, that conversion's result is still stored. No further sample strobe follows, and the sequencer returns to idle.
- R9: If the start bit is 1 while the sequencer is idle and the mask is all zeros, the start bit returns to 0 on the next clock edge and no strobe is issued.
- R10: A write to the start bit takes effect on the next clock edge and is visible on the start-bit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chEnMask | input | 8 | Enable mask, bit n enables input n |
| startWrEn | input | 1 | Write strobe for the start bit |
| startWrData | input | 1 | Value written to the start bit |
| startBit | output | 1 | Current start bit |
| chSel | output | 3 | Input selected for conversion |
| sampleStrobe | output | 1 | One-cycle request to sample chSel |
| convDone | input | 1 | Converter done pulse |
| convResult | input | 12 | Conversion result, valid with convDone |
| rdEn | input | 1 | Read pulse, clears the flag of rdCh |
| rdCh | input | 3 | Input number to read |
| rdData | output | 12 | Data register of rdCh |
| rdValid | output | 1 | Valid flag of rdCh |
| validFlags | output | 8 | All valid flags, bit n for input n |

## Verification
The assertions assume that the enable mask does not change while a scan is running. They also assume the converter sends exactly one done pulse per strobe, only after the strobe, and that the start bit is not set again while the mask is zero. The stimulus changes the mask only while the sequencer is idle. It sends a single done pulse two cycles after each strobe, and it writes the start bit only between scans or once, to stop a scan, before the final done pulse. A sweep over all 256 mask values therefore stays inside these assumptions while it covers every skip and wrap pattern.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SAMPLE = 2'd1,
    SEQ_WAIT   = 2'd2
  } seqState_t;

  typedef struct packed {
    logic loadFirst;
    logic advance;
    logic writeRes;
  } seqStrobes_t;

endpackage

// File: rtl/adc_chan_picker.sv
module adc_chan_picker #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W-1:0]   curCh,
  output logic [CH_W-1:0]   firstCh,
  output logic [CH_W-1:0]   nextCh,
  output logic              anyEn
);

  // Lowest set bit overall, scanned from the top so the lowest wins.
  always_comb begin
    firstCh = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i]) firstCh = CH_W'(i);
    end
  end

  // Lowest set bit strictly above curCh, else wrap to firstCh.
  always_comb begin
    nextCh = firstCh;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i] && (i > int'(curCh))) nextCh = CH_W'(i);
    end
  end

  assign anyEn = |mask;

endmodule

// File: rtl/adc_scan_control.sv
module adc_scan_control
  import adc_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startWrEn,
  input  logic        startWrData,
  input  logic        convDone,
  input  logic        anyEn,
  output logic        startBit,
  output logic        sampleStrobe,
  output seqStrobes_t strobes
);

  seqState_t state, stateNext;
  logic      startReg, startNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    startNext = startReg;
    unique case (state)
      SEQ_IDLE: begin
        if (startReg) begin
          if (anyEn) begin
            strobes.loadFirst = 1'b1;
            stateNext         = SEQ_SAMPLE;
          end else begin
            startNext = 1'b0;
          end
        end
      end
      SEQ_SAMPLE: stateNext = SEQ_WAIT;
      SEQ_WAIT: begin
        if (convDone) begin
          strobes.writeRes = 1'b1;
          if (startReg && anyEn) begin
            strobes.advance = 1'b1;
            stateNext       = SEQ_SAMPLE;
          end else begin
            stateNext = SEQ_IDLE;
            if (!anyEn) startNext = 1'b0;
          end
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
    // A software write overrides the sequencer's own clear.
    if (startWrEn) startNext = startWrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      startReg <= 1'b0;
    end else begin
      state    <= stateNext;
      startReg <= startNext;
    end
  end

  assign startBit     = startReg;
  assign sampleStrobe = (state == SEQ_SAMPLE);

endmodule

// File: rtl/adc_scan_datapath.sv
module adc_scan_datapath
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 12,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobes_t       strobes,
  input  logic [NUM_CH-1:0] chEnMask,
  input  logic [RES_W-1:0]  convResult,
  input  logic              rdEn,
  input  logic [CH_W-1:0]   rdCh,
  output logic              anyEn,
  output logic [CH_W-1:0]   chSel,
  output logic [RES_W-1:0]  rdData,
  output logic              rdValid,
  output logic [NUM_CH-1:0] validFlags
);

  logic [CH_W-1:0]  curCh;
  logic [CH_W-1:0]  firstCh;
  logic [CH_W-1:0]  nextCh;
  logic [RES_W-1:0] dataReg [NUM_CH];
  logic [NUM_CH-1:0] validReg;

  adc_chan_picker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) picker_i (
    .mask    (chEnMask),
    .curCh   (curCh),
    .firstCh (firstCh),
    .nextCh  (nextCh),
    .anyEn   (anyEn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curCh <= '0;
    end else if (strobes.loadFirst) begin
      curCh <= firstCh;
    end else if (strobes.advance) begin
      curCh <= nextCh;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gen_chan
    logic hitWr, hitRd;
    assign hitWr = strobes.writeRes && (curCh == CH_W'(g));
    assign hitRd = rdEn && (rdCh == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dataReg[g]  <= '0;
        validReg[g] <= 1'b0;
      end else if (hitWr) begin
        dataReg[g]  <= convResult;
        validReg[g] <= 1'b1;
      end else if (hitRd) begin
        validReg[g] <= 1'b0;
      end
    end
  end

  assign chSel      = curCh;
  assign rdData     = dataReg[rdCh];
  assign rdValid    = validReg[rdCh];
  assign validFlags = validReg;

endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 12,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chEnMask,
  input  logic              startWrEn,
  input  logic              startWrData,
  output logic              startBit,
  output logic [CH_W-1:0]   chSel,
  output logic              sampleStrobe,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convResult,
  input  logic              rdEn,
  input  logic [CH_W-1:0]   rdCh,
  output logic [RES_W-1:0]  rdData,
  output logic              rdValid,
  output logic [NUM_CH-1:0] validFlags
);

  seqStrobes_t strobes;
  logic        anyEn;

  adc_scan_control control_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .startWrEn    (startWrEn),
    .startWrData  (startWrData),
    .convDone     (convDone),
    .anyEn        (anyEn),
    .startBit     (startBit),
    .sampleStrobe (sampleStrobe),
    .strobes      (strobes)
  );

  adc_scan_datapath #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) datapath_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .chEnMask   (chEnMask),
    .convResult (convResult),
    .rdEn       (rdEn),
    .rdCh       (rdCh),
    .anyEn      (anyEn),
    .chSel      (chSel),
    .rdData     (rdData),
    .rdValid    (rdValid),
    .validFlags (validFlags)
  );

endmodule

// File: rtl/adc_scan_sequencer_chk.sv
module adc_scan_sequencer_chk #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chEnMask,
  input logic              startWrEn,
  input logic              startBit,
  input logic [CH_W-1:0]   chSel,
  input logic              sampleStrobe,
  input logic              convDone,
  input logic [NUM_CH-1:0] validFlags
);

  logic [CH_W-1:0] lastCh;
  logic            havePrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastCh   <= '0;
      havePrev <= 1'b0;
    end else if (sampleStrobe) begin
      lastCh   <= chSel;
      havePrev <= 1'b1;
    end else if (!startBit) begin
      havePrev <= 1'b0;
    end
  end

  // R3
  strobe_on_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStrobe |-> chEnMask[chSel]);

  // R3
  no_skipped_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStrobe && havePrev && (chSel > lastCh)) |->
      ((int'(chEnMask) & ((1 << chSel) - (2 << lastCh))) == 0));

  // R4
  wrap_after_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStrobe && havePrev && (chSel <= lastCh)) |->
      (((int'(chEnMask) >> lastCh) >> 1) == 0));

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStrobe |=> !sampleStrobe);

  // R6
  valid_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    convDone |=> validFlags[$past(chSel)]);

  // R8
  stop_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (convDone && !startBit) |=> !sampleStrobe);

  // R9
  empty_mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(startBit) && (chEnMask == '0) && !startWrEn) |=> !startBit);

endmodule

bind adc_scan_sequencer adc_scan_sequencer_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .chEnMask     (chEnMask),
  .startWrEn    (startWrEn),
  .startBit     (startBit),
  .chSel        (chSel),
  .sampleStrobe (sampleStrobe),
  .convDone     (convDone),
  .validFlags   (validFlags)
);

// File: tb/adc_scan_sequencer_tb.sv
module adc_scan_sequencer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int RW  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NCH-1:0] chEnMask = '0;
  logic          startWrEn = 1'b0;
  logic          startWrData = 1'b0;
  logic          startBit;
  logic [2:0]    chSel;
  logic          sampleStrobe;
  logic          convDone = 1'b0;
  logic [RW-1:0] convResult = '0;
  logic          rdEn = 1'b0;
  logic [2:0]    rdCh = '0;
  logic [RW-1:0] rdData;
  logic          rdValid;
  logic [NCH-1:0] validFlags;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [RW-1:0] expData [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .chEnMask(chEnMask),
    .startWrEn(startWrEn), .startWrData(startWrData), .startBit(startBit),
    .chSel(chSel), .sampleStrobe(sampleStrobe),
    .convDone(convDone), .convResult(convResult),
    .rdEn(rdEn), .rdCh(rdCh), .rdData(rdData), .rdValid(rdValid),
    .validFlags(validFlags)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitStrobe(output bit got);
    got = 0;
    for (int t = 0; t < 20; t++) begin
      if (sampleStrobe) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic runMask(input int m);
    int chans [NCH];
    int pop = 0;
    int nConv;
    bit got;
    for (int c = 0; c < NCH; c++) if (m[c]) begin chans[pop] = c; pop++; end
    nConv = 2 * pop + 1;
    @(negedge clk);
    chEnMask = m[NCH-1:0];
    startWrEn = 1; startWrData = 1;
    @(negedge clk);
    startWrEn = 0;
    check(startBit == 1'b1, "R10", int'(startBit), 1);
    for (int k = 0; k < nConv; k++) begin
      int expCh = chans[k % pop];
      waitStrobe(got);
      if (k == 0)        check(got && chSel == 3'(expCh), "R2", int'(chSel), expCh);
      else if (k == pop) check(got && chSel == 3'(expCh), "R4", int'(chSel), expCh);
      else               check(got && chSel == 3'(expCh), "R3", int'(chSel), expCh);
      @(negedge clk);
      check(!sampleStrobe && chSel == 3'(expCh), "R5", int'(sampleStrobe), 0);
      if (k == nConv - 1) begin startWrEn = 1; startWrData = 0; end
      @(negedge clk);
      startWrEn = 0;
      convDone = 1;
      convResult = RW'((m * 16 + k * 3 + expCh) & 12'hFFF);
      expData[expCh] = convResult;
      @(negedge clk);
      convDone = 0;
    end
    for (int w = 0; w < 6; w++) begin
      check(!sampleStrobe && !startBit, "R8", int'(sampleStrobe), 0);
      @(negedge clk);
    end
    for (int c = 0; c < NCH; c++) begin
      rdCh = 3'(c);
      #1;
      check(rdValid == m[c], "R6", int'(rdValid), int'(m[c]));
      if (m[c]) check(rdData == expData[c], "R6", int'(rdData), int'(expData[c]));
      @(negedge clk);
      rdEn = 1;
      @(negedge clk);
      rdEn = 0;
      #1;
      check(rdValid == 1'b0, "R7", int'(rdValid), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(startBit == 1'b0, "R1", int'(startBit), 0);
    check(sampleStrobe == 1'b0, "R1", int'(sampleStrobe), 0);
    check(validFlags == '0, "R1", int'(validFlags), 0);

    // R9 start with empty mask
    chEnMask = '0;
    startWrEn = 1; startWrData = 1;
    @(negedge clk);
    startWrEn = 0;
    check(startBit == 1'b1, "R10", int'(startBit), 1);
    @(negedge clk);
    check(startBit == 1'b0, "R9", int'(startBit), 0);
    for (int w = 0; w < 4; w++) begin
      check(!sampleStrobe, "R9", int'(sampleStrobe), 0);
      @(negedge clk);
    end

    // sweep every non-empty mask
    for (int m = 1; m < 256; m++) runMask(m);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule